// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes received Ethernet frames from a byte-wide stream and writes them into host memory. The host describes where each frame goes with a ring of 32-byte descriptors. A descriptor that the engine owns carries two buffer addresses and two buffer sizes. The engine fetches the descriptor at the current ring position and checks that it owns it. It stores the frame bytes in buffer 1 and continues into buffer 2 once buffer 1 is full. It then writes a status word back, which hands ownership to the host, and moves on to the next descriptor. The descriptor flagged as the last one sends the engine back to the ring base.

When the fetched descriptor still belongs to the host, the engine suspends. In that state it accepts and discards frames and counts each one it drops. A pulse on the poll-demand input makes it fetch the same descriptor again. Dropping the run input stops the engine once the frame in progress has been written back, and the ring position returns to zero. The memory port moves one 32-bit word per request. It is always granted, and read data arrives on the cycle after the request.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the engine issues no memory request, holds rx_ready_o low while run_i is low, and drop_cnt_o is zero.
- R2: With run_i high, the engine reads words 0 to 3 of the descriptor at ring_base_i + 32 x index. It accepts a frame into that descriptor only if bit 31 of word 0 is set.
- R3: Frame bytes are stored little-endian: byte n of a word sits at bits 8n+7:8n. They start at the buffer 1 address held in word 2. The buffer 1 size is in word 1 bits 12:0. After buffer 1 the bytes continue at the buffer 2 address held in word 3, whose size is in word 1 bits 28:16. Sizes are multiples of 4.
- R4: The status write to word 0 has bit 31 clear. Bits 29:16 hold the number of bytes stored. Bits 9 and 8 are set. Bit 5 copies rx_typed_i, bit 1 copies rx_crc_err_i and bit 11 copies rx_ovf_i, each sampled with the end-of-frame byte. Bit 12 marks truncation. Bit 15 is the OR of bits 1, 11 and 12. Every other bit is 0.
- R5: Bytes beyond the combined capacity of the two buffers are not written. The stored length equals the capacity, and bit 12 is set.
- R6: After the status write the index advances by one. It wraps to 0 after a descriptor whose word 1 bit 15 is set.
- R7: When the fetched descriptor is not owned, the engine keeps rx_ready_o high and drops the frames it receives. It increments drop_cnt_o once per end-of-frame byte and writes nothing to memory. A poll_i pulse makes it fetch that descriptor again.
- R8: If run_i falls during a frame, the engine still completes that frame, including its status write. It then idles with rx_ready_o low, and the next run starts at index 0.
- R9: A buffer 1 size field above 0x1FF8 is treated as 0x1FF8, so byte 0x1FF8 of the frame goes to the start of buffer 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Engine start (high) / stop (low) |
| poll_i | input | 1 | Poll-demand strobe, re-fetches the current descriptor |
| ring_base_i | input | AW | Byte address of descriptor 0 (32-byte aligned) |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_sof_i | input | 1 | First byte of a frame |
| rx_eof_i | input | 1 | Last byte of a frame |
| rx_crc_err_i | input | 1 | CRC error flag, valid with the last byte |
| rx_ovf_i | input | 1 | Upstream overflow flag, valid with the last byte |
| rx_typed_i | input | 1 | Frame-type flag, valid with the last byte |
| rx_ready_o | output | 1 | Byte accepted when high together with rx_valid_i |
| drop_cnt_o | output | DW | Count of frames dropped while suspended |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after a read request |

## Verification
A wrong ring index or a stale ownership bit shows up at the next status write, which lands on the wrong descriptor or never comes. The bench therefore waits a bounded time for ownership to return on the descriptor it expects. A wrong byte count or buffer split shows up in the same status write and in the buffer contents. Guard words placed just past each buffer expose any write beyond the capacity as soon as the frame closes. A fault in the suspend or stop logic appears within a few cycles as a changed drop count, a ready output in the wrong state, or a descriptor touched when it should not be.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int unsigned DESC_BYTES = 32;
  localparam int unsigned OWN_BIT    = 31;
  localparam int unsigned LEN_LSB    = 16;
  localparam int unsigned LEN_W      = 14;
  localparam int unsigned ES_BIT     = 15;
  localparam int unsigned LE_BIT     = 12;
  localparam int unsigned OE_BIT     = 11;
  localparam int unsigned FS_BIT     = 9;
  localparam int unsigned LS_BIT     = 8;
  localparam int unsigned FT_BIT     = 5;
  localparam int unsigned CE_BIT     = 1;
  localparam int unsigned EOR_BIT    = 15;
  localparam int unsigned SZ_W       = 13;
  localparam int unsigned SZ2_LSB    = 16;
  localparam logic [SZ_W-1:0] B1_MAX = 13'h1FF8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SUSP, ST_WAIT, ST_RECV, ST_WB
  } rxd_state_e;
endpackage

// File: rtl/rxd_pack.sv
module rxd_pack
  import rxd_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  logic             first_i,
  input  logic             eof_i,
  input  logic [7:0]       byte_i,
  input  logic [SZ_W-1:0]  b1_size_i,
  input  logic [SZ_W-1:0]  b2_size_i,
  input  logic [AW-1:0]    b1_addr_i,
  input  logic [AW-1:0]    b2_addr_i,
  output logic             wr_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [31:0]      wr_data_o,
  output logic [LEN_W-1:0] len_o,
  output logic             trunc_o
);
  logic [CW-1:0]    cnt_q, cnt_eff, cap_ext, b1_ext, off2;
  logic [31:0]      acc_q, acc_nxt;
  logic [LEN_W-1:0] b1_cap, cap;
  logic [1:0]       lane;
  logic             store_ok, in_b1, last_in_cap;

  // clamp buffer 1 at the fixed break
  assign b1_cap  = (b1_size_i > B1_MAX) ? LEN_W'(B1_MAX) : LEN_W'(b1_size_i);
  assign cap     = b1_cap + LEN_W'(b2_size_i);
  assign cap_ext = CW'(cap);
  assign b1_ext  = CW'(b1_cap);

  assign cnt_eff     = first_i ? '0 : cnt_q;
  assign lane        = cnt_eff[1:0];
  assign store_ok    = cnt_eff < cap_ext;
  assign last_in_cap = (cnt_eff + CW'(1)) == cap_ext;
  assign in_b1       = cnt_eff < b1_ext;
  assign off2        = cnt_eff - b1_ext;

  always_comb begin
    acc_nxt = first_i ? '0 : acc_q;
    acc_nxt[{lane, 3'b000} +: 8] = byte_i;
  end

  assign wr_o      = byte_vld_i && store_ok && (lane == 2'd3 || eof_i || last_in_cap);
  assign wr_data_o = acc_nxt;
  assign wr_addr_o = in_b1 ? b1_addr_i + AW'({cnt_eff[CW-1:2], 2'b00})
                           : b2_addr_i + AW'({off2[CW-1:2], 2'b00});

  assign trunc_o = cnt_q > cap_ext;
  assign len_o   = trunc_o ? cap : cnt_q[LEN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (byte_vld_i) begin
      cnt_q <= (&cnt_eff) ? cnt_eff : cnt_eff + CW'(1);
      acc_q <= (lane == 2'd3) ? '0 : acc_nxt;
    end
  end

  assert_first_restarts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && first_i) |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 10,
  parameter int DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             poll_i,
  input  logic [AW-1:0]    ring_base_i,
  input  logic             rx_valid_i,
  input  logic             rx_sof_i,
  input  logic             rx_eof_i,
  input  logic             rx_crc_err_i,
  input  logic             rx_ovf_i,
  input  logic             rx_typed_i,
  output logic             rx_ready_o,
  output logic [DW-1:0]    drop_cnt_o,
  output logic             byte_vld_o,
  output logic             first_o,
  input  logic             pack_wr_i,
  input  logic [AW-1:0]    pack_addr_i,
  input  logic [31:0]      pack_data_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             trunc_i,
  output logic [SZ_W-1:0]  b1_size_o,
  output logic [SZ_W-1:0]  b2_size_o,
  output logic [AW-1:0]    b1_addr_o,
  output logic [AW-1:0]    b2_addr_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i
);
  localparam int DSH = $clog2(DESC_BYTES);

  rxd_state_e     st_q, st_d;
  logic [2:0]     fcnt_q, fcnt_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic           own_q, eor_q, crc_q, ovf_q, typ_q;
  logic [DW-1:0]  drop_q;
  logic [AW-1:0]  desc_addr;
  logic [31:0]    wb_word;
  logic           take, eof_take;

  assign rx_ready_o = (st_q == ST_WAIT) || (st_q == ST_RECV) || (st_q == ST_SUSP);
  assign take       = rx_valid_i && rx_ready_o;
  assign byte_vld_o = take && ((st_q == ST_WAIT && rx_sof_i) || st_q == ST_RECV);
  assign first_o    = (st_q == ST_WAIT);
  assign eof_take   = byte_vld_o && rx_eof_i;
  assign desc_addr  = ring_base_i + (AW'(idx_q) << DSH);
  assign drop_cnt_o = drop_q;

  always_comb begin
    st_d = st_q; fcnt_d = fcnt_q; idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: if (run_i) begin st_d = ST_FETCH; fcnt_d = '0; end
      ST_FETCH:
        if (!run_i) begin st_d = ST_IDLE; idx_d = '0; end
        else if (fcnt_q == 3'd4) st_d = own_q ? ST_WAIT : ST_SUSP;
        else fcnt_d = fcnt_q + 3'd1;
      ST_SUSP:
        if (!run_i) begin st_d = ST_IDLE; idx_d = '0; end
        else if (poll_i) begin st_d = ST_FETCH; fcnt_d = '0; end
      ST_WAIT:
        if (take && rx_sof_i) st_d = rx_eof_i ? ST_WB : ST_RECV;
        else if (!run_i) begin st_d = ST_IDLE; idx_d = '0; end
      ST_RECV: if (take && rx_eof_i) st_d = ST_WB;
      ST_WB: begin
        fcnt_d = '0;
        idx_d  = eor_q ? '0 : idx_q + IW'(1);
        if (run_i) st_d = ST_FETCH;
        else begin st_d = ST_IDLE; idx_d = '0; end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wb_word = '0;
    wb_word[LEN_LSB +: LEN_W] = len_i;
    wb_word[FS_BIT] = 1'b1;
    wb_word[LS_BIT] = 1'b1;
    wb_word[FT_BIT] = typ_q;
    wb_word[CE_BIT] = crc_q;
    wb_word[OE_BIT] = ovf_q;
    wb_word[LE_BIT] = trunc_i;
    wb_word[ES_BIT] = crc_q | ovf_q | trunc_i;
  end

  always_comb begin
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = desc_addr; mem_wdata_o = wb_word;
    if (st_q == ST_FETCH) begin
      mem_req_o  = run_i && (fcnt_q < 3'd4);
      mem_addr_o = desc_addr + AW'({fcnt_q[1:0], 2'b00});
    end else if (st_q == ST_WB) begin
      mem_req_o = 1'b1; mem_we_o = 1'b1;
    end else begin
      mem_req_o = pack_wr_i; mem_we_o = 1'b1;
      mem_addr_o = pack_addr_i; mem_wdata_o = pack_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; fcnt_q <= '0; idx_q <= '0; own_q <= 1'b0; eor_q <= 1'b0;
      b1_size_o <= '0; b2_size_o <= '0; b1_addr_o <= '0; b2_addr_o <= '0;
      crc_q <= 1'b0; ovf_q <= 1'b0; typ_q <= 1'b0; drop_q <= '0;
    end else begin
      st_q <= st_d; fcnt_q <= fcnt_d; idx_q <= idx_d;
      if (st_q == ST_FETCH) begin
        unique case (fcnt_q)
          3'd1: own_q <= mem_rdata_i[OWN_BIT];
          3'd2: begin
            eor_q     <= mem_rdata_i[EOR_BIT];
            b1_size_o <= mem_rdata_i[SZ_W-1:0];
            b2_size_o <= mem_rdata_i[SZ2_LSB +: SZ_W];
          end
          3'd3: b1_addr_o <= mem_rdata_i[AW-1:0];
          3'd4: b2_addr_o <= mem_rdata_i[AW-1:0];
          default: ;
        endcase
      end
      if (eof_take) begin
        crc_q <= rx_crc_err_i; ovf_q <= rx_ovf_i; typ_q <= rx_typed_i;
      end
      if (st_q == ST_SUSP && take && rx_eof_i) drop_q <= drop_q + DW'(1);
    end
  end

  assert_wb_follows_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WB) |-> ($past(st_q) == ST_RECV || $past(st_q) == ST_WAIT));
  assert_wb_needs_own_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WB) |-> own_q);
  assert_susp_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSP) |-> !mem_req_o);
  assert_idle_index_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (idx_q == '0));
  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WB && eor_q) |=> (idx_q == '0));
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rxd_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 10,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          poll_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_sof_i,
  input  logic          rx_eof_i,
  input  logic          rx_crc_err_i,
  input  logic          rx_ovf_i,
  input  logic          rx_typed_i,
  output logic          rx_ready_o,
  output logic [DW-1:0] drop_cnt_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i
);
  logic             byte_vld, first, pack_wr, trunc;
  logic [AW-1:0]    pack_addr, b1_addr, b2_addr;
  logic [31:0]      pack_data;
  logic [LEN_W-1:0] len;
  logic [SZ_W-1:0]  b1_size, b2_size;

  rxd_ctrl #(.AW(AW), .IW(IW), .DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .run_i, .poll_i, .ring_base_i,
    .rx_valid_i, .rx_sof_i, .rx_eof_i, .rx_crc_err_i, .rx_ovf_i, .rx_typed_i,
    .rx_ready_o, .drop_cnt_o,
    .byte_vld_o(byte_vld), .first_o(first),
    .pack_wr_i(pack_wr), .pack_addr_i(pack_addr), .pack_data_i(pack_data),
    .len_i(len), .trunc_i(trunc),
    .b1_size_o(b1_size), .b2_size_o(b2_size), .b1_addr_o(b1_addr), .b2_addr_o(b2_addr),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i
  );

  rxd_pack #(.AW(AW), .CW(CW)) u_pack (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .first_i(first), .eof_i(rx_eof_i), .byte_i(rx_data_i),
    .b1_size_i(b1_size), .b2_size_i(b2_size), .b1_addr_i(b1_addr), .b2_addr_i(b2_addr),
    .wr_o(pack_wr), .wr_addr_o(pack_addr), .wr_data_o(pack_data),
    .len_o(len), .trunc_o(trunc)
  );
endmodule

// File: tb/rx_ring_dma_tb_top.sv
`timescale 1ns/1ps
module rx_ring_dma_tb_top;
  localparam int NDESC = 4;
  localparam logic [31:0] RING = 32'h1000;
  localparam logic [31:0] SENT = 32'hA5A5_5A5A;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, poll = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic rx_crc = 1'b0, rx_ovf = 1'b0, rx_typ = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, mem_req, mem_we;
  logic [7:0] drop_cnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  logic [31:0] mem [int];
  logic [7:0]  fb [0:8299];
  int d_s1 [NDESC], d_s2 [NDESC];
  logic [31:0] d_a1 [NDESC], d_a2 [NDESC];
  int checks = 0, fails = 0, exp_idx = 0;

  always #10 clk = ~clk;

  rx_ring_dma dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .poll_i(poll), .ring_base_i(RING),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof),
    .rx_crc_err_i(rx_crc), .rx_ovf_i(rx_ovf), .rx_typed_i(rx_typ),
    .rx_ready_o(rx_ready), .drop_cnt_o(drop_cnt),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(int'(a >> 2))) return mem[int'(a >> 2)];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[int'(mem_addr >> 2)] = mem_wdata;
      else mem_rdata <= rd(mem_addr);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  function automatic int eff1(input int s1);
    return (s1 > 'h1FF8) ? 'h1FF8 : s1;
  endfunction

  function automatic int cap_of(input int i);
    return eff1(d_s1[i]) + d_s2[i];
  endfunction

  task automatic arm(input int i, input int s1, input int s2, input logic [31:0] a1,
                     input logic [31:0] a2);
    logic [31:0] da;
    da = RING + 32 * i;
    d_s1[i] = s1; d_s2[i] = s2; d_a1[i] = a1; d_a2[i] = a2;
    mem[int'((da + 4) >> 2)]  = (i == NDESC - 1 ? 32'h8000 : 32'h0) | (32'(s2) << 16) | 32'(s1);
    mem[int'((da + 8) >> 2)]  = a1;
    mem[int'((da + 12) >> 2)] = a2;
    mem[int'((a1 + 32'(eff1(s1))) >> 2)] = SENT;
    mem[int'((a2 + 32'(s2)) >> 2)] = SENT;
    mem[int'(da >> 2)] = 32'h8000_0000;
  endtask

  task automatic arm_rand(input int i);
    arm(i, 4 << $urandom_range(0, 3), 4 * $urandom_range(0, 4),
        32'h8000 + 32'(i) * 32'h400, 32'h8200 + 32'(i) * 32'h400);
  endtask

  task automatic drive_frame(input int len, input bit crc, input bit ovf, input bit typ,
                             input int stop_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fb[i];
      rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_crc = (i == len - 1) && crc; rx_ovf = (i == len - 1) && ovf;
      rx_typ = (i == len - 1) && typ;
      if (i == stop_at) run = 1'b0;
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    rx_crc = 1'b0; rx_ovf = 1'b0; rx_typ = 1'b0;
  endtask

  task automatic fill(input int len);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
  endtask

  task automatic check_frame(input int len, input bit crc, input bit ovf, input bit typ);
    int d, t, cap, st, e1, bad;
    bit tr;
    logic [31:0] da, w, ex, a, fa, fe;
    d = exp_idx; da = RING + 32 * d; t = 0;
    w = rd(da);
    while (w[31] && t < 30000) begin @(negedge clk); t++; w = rd(da); end
    chk("R2 R6 descriptor returned", {31'h0, w[31]}, 32'h0);
    e1 = eff1(d_s1[d]); cap = e1 + d_s2[d];
    tr = len > cap; st = tr ? cap : len;
    ex = (32'(st) << 16) | 32'h300 | (32'(typ) << 5) | (32'(crc) << 1) |
         (32'(ovf) << 11) | (32'(tr) << 12) | (32'(crc | ovf | tr) << 15);
    chk(tr ? "R5 truncated status" : "R4 status word", w, ex);
    bad = 0; fa = '0; fe = '0;
    for (int i = 0; i < st; i++) begin
      a = (i < e1) ? d_a1[d] + 32'(i) : d_a2[d] + 32'(i - e1);
      if (8'(rd(a & ~32'h3) >> (8 * a[1:0])) !== fb[i]) begin
        if (bad == 0) begin fa = 32'(8'(rd(a & ~32'h3) >> (8 * a[1:0]))); fe = 32'(fb[i]); end
        bad++;
      end
    end
    chk("R3 buffer bytes", fa, fe);
    chk("R5 guard after buffer 1", rd(d_a1[d] + 32'(e1)), SENT);
    chk("R5 guard after buffer 2", rd(d_a2[d] + 32'(d_s2[d])), SENT);
    arm_rand(d);
    exp_idx = (d == NDESC - 1) ? 0 : d + 1;  // R6 wrap on end-of-ring entry
  endtask

  task automatic frame(input int len);
    bit c, o, y;
    c = 1'($urandom); o = 1'($urandom); y = 1'($urandom);
    fill(len);
    drive_frame(len, c, o, y, -1);
    check_frame(len, c, o, y);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    int nxt;
    logic [7:0] d0;
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", {31'h0, rx_ready}, 32'h0);
    chk("R1 no request after reset", {31'h0, mem_req}, 32'h0);
    chk("R1 drop count after reset", {24'h0, drop_cnt}, 32'h0);

    for (int i = 0; i < NDESC; i++) arm_rand(i);
    exp_idx = 0; run = 1'b1;
    for (int k = 0; k < 16; k++) frame($urandom_range(1, 40));

    frame(cap_of(exp_idx) + 7);   // R5 overrun
    frame(cap_of(exp_idx));       // exactly full
    frame(1);                     // single byte frame

    // R7: next descriptor left with the host
    nxt = (exp_idx == NDESC - 1) ? 0 : exp_idx + 1;
    mem[int'((RING + 32 * nxt) >> 2)] = 32'h0;
    frame(12);
    repeat (30) @(negedge clk);
    d0 = drop_cnt;
    chk("R7 ready while suspended", {31'h0, rx_ready}, 32'h1);
    fill(9);  drive_frame(9, 1'b0, 1'b0, 1'b0, -1);
    fill(20); drive_frame(20, 1'b1, 1'b0, 1'b0, -1);
    repeat (5) @(negedge clk);
    chk("R7 drop count", 32'(8'(drop_cnt - d0)), 32'h2);
    chk("R7 unowned descriptor untouched", rd(RING + 32 * nxt), 32'h0);
    arm_rand(nxt);
    repeat (10) @(negedge clk);
    chk("R7 still suspended before poll", rd(RING + 32 * nxt), 32'h8000_0000);
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
    frame(17);

    // R8: stop in mid frame
    fill(20);
    drive_frame(20, 1'b0, 1'b0, 1'b1, 5);
    check_frame(20, 1'b0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk("R8 ready low when stopped", {31'h0, rx_ready}, 32'h0);
    chk("R8 no request when stopped", {31'h0, mem_req}, 32'h0);
    for (int i = 1; i < NDESC; i++) arm_rand(i);
    arm(0, 'h1FFF, 16, 32'h10000, 32'h20000);  // R9 oversize buffer 1 field
    exp_idx = 0;
    run = 1'b1;
    frame(8200);                  // R8 restart at index 0, R9 split at 0x1FF8
    chk("R9 first byte of buffer 2", 32'(8'(rd(32'h20000))), 32'(fb['h1FF8]));
    frame(30);

    report();
    $finish;
  end
endmodule